// File: doc/BRIEF.md
# SPI Master/Slave Controller

This block is a byte-wide, full-duplex SPI controller that works either as the clock-generating master or as a slave clocked from outside. Software sees three byte registers: control, status and data. In master mode, a write to the data register goes straight into the shift register and the transfer starts at once. SCK is derived from the system clock at one of four rates, and data leaves on MOSI most significant bit first. In slave mode, the block follows an external SCK while the active-low select is held low. It shifts in from MOSI and drives MISO.

The block has no transmit buffer and one receive buffer. A finished byte raises a completion flag and lands in the receive buffer. Writing the data register during a transfer raises a collision flag, and the write is dropped. A select pulled low while the block is master raises a fault and drops the block out of master mode. All flags clear the same way: a status read that sees a flag, followed by a data-register access. External SCK and select are synchronised into the system clock domain, so a slave SCK half-period must span several system clocks.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset, control reads 0x04 (only the phase bit set), status reads 0x00, the interrupt output is low and SCK sits at 0.
- R2: Address 0 is control: bit 7 interrupt enable, bit 6 enable, bit 5 always reads 0, bit 4 master, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate. Address 1 is status: bit 7 complete, bit 6 collision, bit 4 fault, all other bits 0. Address 2 is data, and address 3 reads 0x00.
- R3: With enable and master set and no transfer running, a data write starts a transfer. SCK idles at the polarity bit. MOSI carries the written byte MSB first. With phase 0, data is sampled on the leading SCK edge; with phase 1, on the trailing edge.
- R4: The SCK half-period is 1, 2, 8 or 16 system clocks for rate codes 00, 01, 10 and 11.
- R5: A transfer has exactly 16 SCK edges. After the last edge, the complete flag sets and the byte received on MISO, MSB first, is readable at address 2.
- R6: A data write while a transfer runs sets the collision flag. The byte being shifted out is not changed.
- R7: A data read or write clears the complete, collision and fault flags only if it follows a status read that saw a flag set. A data access with no such status read before it leaves the flags unchanged.
- R8: If the synchronised select is low while enable and master are both set, the block clears enable and master and sets the fault flag.
- R9: The interrupt output is high exactly when interrupt enable is set and either the complete or the fault flag is set.
- R10: In slave mode with select low, the block shifts on external SCK edges, using the same polarity and phase rules as R3. It drives the loaded byte MSB first on MISO, and after eight bits the received byte sets the complete flag and is readable at address 2.
- R11: In slave mode with phase 0, once a byte completes, further SCK edges are ignored until select goes high again.
- R12: In slave mode with phase 1, select may stay low across consecutive bytes, and each byte completes on its own.
- R13: If a byte completes while the complete flag is still set, the byte is discarded and the data register keeps the earlier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers flag-clear sequencing) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| ss_n_i | input | 1 | Active-low select, also the fault detect in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode while selected |
| miso_i | input | 1 | Serial data in for master mode |

## Verification
A wrong edge count or divider value is visible at once on sck_o. It shows as a wrong interval between the first two SCK edges or a wrong edge total, and the complete flag then appears early, late or never within one byte time. A shift register or phase selection that is off shows as MOSI bits out of order at the sample edges, or as a wrong byte read back at address 2, in the byte that is affected. A flag clear sequence that is armed wrongly shows in the status read immediately after the data access. A slave that fails to stop after a phase-0 byte shows in the next byte's MISO pattern and in a complete flag that should have stayed clear.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

    localparam int BYTE_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // control byte, bit 7 down to bit 0
    typedef struct packed {
        logic       ie;
        logic       en;
        logic       rsv;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{ie: 1'b0, en: 1'b0, rsv: 1'b0, master: 1'b0,
                                   cpol: 1'b0, cpha: 1'b1, rate: 2'b00};

    // status byte, bit 7 down to bit 0
    typedef struct packed {
        logic       done;
        logic       collide;
        logic       zero5;
        logic       fault;
        logic [3:0] zero_lo;
    } stat_t;

    // system clocks per SCK half-period
    function automatic int unsigned half_period(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

    function automatic stat_t pack_status(input logic d, input logic c, input logic f);
        stat_t s;
        s         = '0;
        s.done    = d;
        s.collide = c;
        s.fault   = f;
        return s;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_sckgen.sv
module spi_sckgen import spi_ctl_pkg::*; #(
    parameter int CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick,
    output logic       phase
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    assign lim  = CNT_W'(half_period(rate) - 1);
    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_shreg.sv
module spi_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         abort,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         lead,
    input  logic         trail,
    input  logic         cpha,
    input  logic         din,
    output logic         dout,
    output logic [W-1:0] shreg,
    output logic         mid,
    output logic         last
);
    localparam int EW = $clog2(2 * W);
    localparam logic [EW-1:0] ELAST = EW'(2 * W - 1);

    logic [EW-1:0] ecnt_q;
    logic          lat_q;
    logic          obit_q;

    assign mid  = (ecnt_q != '0);
    assign last = trail && !abort && (ecnt_q == ELAST);
    assign dout = cpha ? obit_q : shreg[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ecnt_q <= '0;
        end else if (abort) begin
            ecnt_q <= '0;
        end else if (lead || trail) begin
            ecnt_q <= (ecnt_q == ELAST) ? '0 : ecnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            lat_q  <= 1'b0;
            obit_q <= 1'b0;
        end else if (load) begin
            shreg <= load_val;
        end else if (!abort) begin
            if (lead) begin
                if (cpha) obit_q <= shreg[W-1];
                else      lat_q  <= din;
            end
            if (trail) begin
                if (cpha) shreg <= {shreg[W-2:0], din};
                else      shreg <= {shreg[W-2:0], lat_q};
            end
        end
    end
endmodule

// File: rtl/spi_flagbank.sv
module spi_flagbank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         last,
    input  logic [W-1:0] shreg,
    input  logic         wcol_evt,
    input  logic         modf_evt,
    input  logic         stat_rd,
    input  logic         data_acc,
    output logic         done,
    output logic         spif,
    output logic         wcol,
    output logic         modf,
    output logic [W-1:0] rxbuf
);
    logic arm_q;
    logic clr;

    assign clr = data_acc && arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            spif  <= 1'b0;
            wcol  <= 1'b0;
            modf  <= 1'b0;
            arm_q <= 1'b0;
        end else begin
            done <= last;
            if (done)          spif <= 1'b1;
            else if (clr)      spif <= 1'b0;
            if (wcol_evt)      wcol <= 1'b1;
            else if (clr)      wcol <= 1'b0;
            if (modf_evt)      modf <= 1'b1;
            else if (clr)      modf <= 1'b0;
            if (clr)           arm_q <= 1'b0;
            else if (stat_rd && (spif || wcol || modf)) arm_q <= 1'b1;
        end
    end

    // receive buffer keeps its contents across reset
    always_ff @(posedge clk) begin
        if (done && !spif) rxbuf <= shreg;
    end
endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top import spi_ctl_pkg::*; #(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [BYTE_W-1:0]   reg_wdata,
    output logic [BYTE_W-1:0]   reg_rdata,
    output logic                irq,
    output logic                sck_o,
    input  logic                sck_i,
    input  logic                ss_n_i,
    output logic                mosi_o,
    input  logic                mosi_i,
    output logic                miso_o,
    input  logic                miso_i
);
    ctrl_t ctrl_q;
    logic  ss_s, sck_s, sck_d;
    logic  run_q, hold_q;
    logic  tick, phase;
    logic  master_mode, slave_act, sck_chg;
    logic  m_lead, m_trail, s_lead, s_trail;
    logic  ctrl_wr, data_wr, data_rd, stat_rd;
    logic  busy, load, abort, modf_evt, wcol_evt;
    logic  dout, mid, last, done;
    logic  spif, wcol, modf;
    logic  [BYTE_W-1:0] shreg, rxbuf;

    spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
        .clk(clk), .rst(rst), .d(ss_n_i), .q(ss_s));
    spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst(rst), .d(sck_i), .q(sck_s));

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    // register strobes
    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
    assign data_wr = reg_wr && (reg_addr == ADDR_DATA);
    assign data_rd = reg_rd && (reg_addr == ADDR_DATA);
    assign stat_rd = reg_rd && (reg_addr == ADDR_STAT);

    // mode and edge qualification
    assign master_mode = ctrl_q.en && ctrl_q.master;
    assign slave_act   = ctrl_q.en && !ctrl_q.master && !ss_s && !hold_q;
    assign sck_chg     = sck_s ^ sck_d;
    assign s_lead      = slave_act && sck_chg && (sck_s != ctrl_q.cpol);
    assign s_trail     = slave_act && sck_chg && (sck_s == ctrl_q.cpol);
    assign m_lead      = tick && !phase;
    assign m_trail     = tick && phase;

    assign busy     = run_q || mid;
    assign load     = data_wr && !busy;
    assign wcol_evt = data_wr && busy;
    assign modf_evt = master_mode && !ss_s;
    assign abort    = !ctrl_q.en || modf_evt || (!ctrl_q.master && ss_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else begin
            if (ctrl_wr) begin
                ctrl_q     <= ctrl_t'(reg_wdata);
                ctrl_q.rsv <= 1'b0;
            end
            if (modf_evt) begin
                ctrl_q.en     <= 1'b0;
                ctrl_q.master <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (abort || last)              run_q <= 1'b0;
            else if (load && master_mode)   run_q <= 1'b1;
            if (ss_s || !ctrl_q.en || ctrl_q.master) hold_q <= 1'b0;
            else if (last && !ctrl_q.cpha)           hold_q <= 1'b1;
        end
    end

    spi_sckgen #(.CNT_W(DIV_W)) u_sckgen (
        .clk(clk), .rst(rst), .run(run_q), .rate(ctrl_q.rate),
        .tick(tick), .phase(phase));

    spi_shreg #(.W(BYTE_W)) u_shreg (
        .clk(clk), .rst(rst), .abort(abort), .load(load), .load_val(reg_wdata),
        .lead(m_lead || s_lead), .trail(m_trail || s_trail), .cpha(ctrl_q.cpha),
        .din(ctrl_q.master ? miso_i : mosi_i),
        .dout(dout), .shreg(shreg), .mid(mid), .last(last));

    spi_flagbank #(.W(BYTE_W)) u_flags (
        .clk(clk), .rst(rst), .last(last), .shreg(shreg),
        .wcol_evt(wcol_evt), .modf_evt(modf_evt), .stat_rd(stat_rd),
        .data_acc(data_wr || data_rd),
        .done(done), .spif(spif), .wcol(wcol), .modf(modf), .rxbuf(rxbuf));

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_STAT: reg_rdata = pack_status(spif, wcol, modf);
            ADDR_DATA: reg_rdata = rxbuf;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq    = ctrl_q.ie && (spif || modf);
    assign sck_o  = phase ^ ctrl_q.cpol;
    assign mosi_o = master_mode ? dout : 1'b0;
    assign miso_o = (ctrl_q.en && !ctrl_q.master && !ss_s) ? dout : 1'b0;
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         modf_evt,
    input logic         en,
    input logic         master,
    input logic         ie,
    input logic         cpol,
    input logic         modf,
    input logic         data_wr,
    input logic         busy,
    input logic         wcol,
    input logic         last,
    input logic         spif,
    input logic         done,
    input logic         run,
    input logic         sck_o,
    input logic         irq,
    input logic [W-1:0] rxbuf
);
    // R8: a fault drops master and enable and raises the fault flag
    p_fault_drops_master_r8: assert property (@(posedge clk) disable iff (rst)
        modf_evt |=> (!en && !master && modf));

    // R6: a data write during a transfer raises the collision flag
    p_collision_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (data_wr && busy) |=> wcol);

    // R5: completion flag follows the last SCK edge
    p_done_after_last_r5: assert property (@(posedge clk) disable iff (rst)
        last |=> ##1 spif);

    // R3: SCK sits at the polarity level whenever no master transfer runs
    p_sck_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !run |-> (sck_o == cpol));

    // R13: a byte completing on a set flag leaves the receive buffer alone
    p_overrun_keeps_r13: assert property (@(posedge clk) disable iff (rst)
        (done && spif) |=> $stable(rxbuf));

    // R9: the interrupt is never raised without its enable
    p_irq_enable_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie);
endmodule

bind spi_ctl_top spi_ctl_chk #(.W(spi_ctl_pkg::BYTE_W)) u_chk (
    .clk(clk), .rst(rst), .modf_evt(modf_evt), .en(ctrl_q.en),
    .master(ctrl_q.master), .ie(ctrl_q.ie), .cpol(ctrl_q.cpol), .modf(modf),
    .data_wr(data_wr), .busy(busy), .wcol(wcol), .last(last), .spif(spif),
    .done(done), .run(run_q), .sck_o(sck_o), .irq(irq), .rxbuf(rxbuf));

// File: tb/sim_spi_ctl_top.sv
`timescale 1ns/1ps
module sim_spi_ctl_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, sck_o, mosi_o, miso_o;
    logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    spi_ctl_top u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck_o(sck_o),
        .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_o(mosi_o), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_i(miso_i));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // master-side partner model: watches sck_o, records mosi, drives miso
    logic       mon_on = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
    logic [7:0] mon_tx = 8'h00, mon_bits = 8'h00;
    int         mon_idx = 0, mon_edges = 0;
    realtime    mon_t1 = 0, mon_t2 = 0;

    always @(sck_o) begin
        if (mon_on) begin
            mon_edges++;
            if (mon_edges == 1) mon_t1 = $realtime;
            if (mon_edges == 2) mon_t2 = $realtime;
            #1;
            if ((sck_o != mon_cpol) ^ mon_cpha) begin
                mon_bits = {mon_bits[6:0], mosi_o};
                mon_idx++;
                if (mon_idx < 8) miso_i = mon_tx[3'(7 - mon_idx)];
            end
        end
    end

    task automatic mon_arm(input logic cpol, input logic cpha, input logic [7:0] tx);
        mon_cpol = cpol; mon_cpha = cpha; mon_tx = tx;
        mon_idx = 0; mon_edges = 0; mon_bits = 8'h00;
        miso_i = tx[7];
        mon_on = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] r;
        chk("R1 irq", irq, 0);
        chk("R1 sck", sck_o, 0);
        reg_read(2'd0, r); chk("R1 ctrl", r, 8'h04);
        reg_read(2'd1, r); chk("R1 status", r, 8'h00);
        reg_read(2'd3, r); chk("R2 addr3", r, 8'h00);
        reg_write(2'd0, 8'hFF);
        reg_read(2'd0, r); chk("R2 bit5", r, 8'hDF);
        reg_write(2'd0, 8'h04);
    endtask

    task automatic t_master(input logic ie, input logic cpol, input logic cpha,
                            input logic [1:0] rate, input logic [7:0] tx, input logic [7:0] slv);
        logic [7:0] r;
        int half;
        half = (rate == 2'b00) ? 1 : (rate == 2'b01) ? 2 : (rate == 2'b10) ? 8 : 16;
        reg_write(2'd0, {ie, 1'b1, 1'b0, 1'b1, cpol, cpha, rate});
        idle(2);
        chk("R3 idle level", sck_o, cpol);
        mon_arm(cpol, cpha, slv);
        reg_write(2'd2, tx);
        idle(16 * half + 8);
        mon_on = 1'b0;
        chk("R5 edge count", mon_edges, 16);
        chk("R3 mosi order", mon_bits, tx);
        chk("R4 half period", ((mon_t2 - mon_t1) > half * 5.0 - 0.1) &&
                              ((mon_t2 - mon_t1) < half * 5.0 + 0.1), 1);
        chk("R3 idle after", sck_o, cpol);
        chk("R9 irq on done", irq, ie);
        reg_read(2'd1, r); chk("R5 status", r, 8'h80);
        reg_read(2'd2, r); chk("R5 rx byte", r, slv);
        reg_read(2'd1, r); chk("R7 cleared", r, 8'h00);
        chk("R9 irq cleared", irq, 0);
    endtask

    task automatic t_collision();
        logic [7:0] r;
        reg_write(2'd0, 8'h52);
        idle(2);
        mon_arm(1'b0, 1'b0, 8'h5A);
        reg_write(2'd2, 8'hC3);
        idle(20);
        reg_write(2'd2, 8'hFF);
        idle(16 * 8 + 8);
        mon_on = 1'b0;
        chk("R6 mosi unchanged", mon_bits, 8'hC3);
        reg_read(2'd1, r); chk("R6 status", r, 8'hC0);
        reg_read(2'd2, r); chk("R6 rx byte", r, 8'h5A);
        reg_read(2'd1, r); chk("R7 both cleared", r, 8'h00);
    endtask

    task automatic t_clear_order();
        logic [7:0] r;
        reg_write(2'd0, 8'h50);
        idle(2);
        mon_arm(1'b0, 1'b0, 8'h3C);
        reg_write(2'd2, 8'h99);
        idle(16 + 8);
        mon_on = 1'b0;
        reg_read(2'd2, r);
        reg_read(2'd1, r); chk("R7 no clear w/o status read", r, 8'h80);
        reg_write(2'd0, 8'h04);
        reg_write(2'd2, 8'h11);
        reg_read(2'd1, r); chk("R7 write clears", r, 8'h00);
    endtask

    task automatic t_fault();
        logic [7:0] r;
        reg_write(2'd0, 8'hD4);
        idle(2);
        ss_n_i = 1'b0;
        idle(6);
        reg_read(2'd0, r); chk("R8 ctrl after fault", r, 8'h84);
        reg_read(2'd1, r); chk("R8 status", r, 8'h10);
        chk("R9 irq on fault", irq, 1);
        ss_n_i = 1'b1;
        idle(4);
        reg_read(2'd2, r);
        reg_read(2'd1, r); chk("R7 fault cleared", r, 8'h00);
        chk("R9 irq after clear", irq, 0);
    endtask

    // external master driving the slave; 8 system clocks per half-period
    task automatic s_shift(input logic cpol, input logic cpha, input logic [7:0] b,
                           output logic [7:0] cap);
        cap = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                mosi_i = b[i];
                idle(8);
                cap = {cap[6:0], miso_o};
                sck_i = ~cpol;
                idle(8);
                sck_i = cpol;
            end else begin
                sck_i = ~cpol;
                mosi_i = b[i];
                idle(8);
                cap = {cap[6:0], miso_o};
                sck_i = cpol;
                idle(8);
            end
        end
        idle(8);
    endtask

    task automatic t_slave_ph0();
        logic [7:0] r, cap;
        sck_i = 1'b0;
        reg_write(2'd0, 8'h40);
        reg_write(2'd2, 8'h96);
        ss_n_i = 1'b0;
        idle(4);
        s_shift(1'b0, 1'b0, 8'h3A, cap);
        chk("R10 miso byte", cap, 8'h96);
        reg_read(2'd1, r); chk("R10 status", r, 8'h80);
        reg_read(2'd2, r); chk("R10 rx byte", r, 8'h3A);
        reg_write(2'd2, 8'h0F);
        s_shift(1'b0, 1'b0, 8'hE1, cap);
        reg_read(2'd1, r); chk("R11 edges ignored", r, 8'h00);
        ss_n_i = 1'b1;
        idle(4);
        ss_n_i = 1'b0;
        idle(4);
        s_shift(1'b0, 1'b0, 8'hE1, cap);
        chk("R11 shifter untouched", cap, 8'h0F);
        reg_read(2'd1, r); chk("R11 status", r, 8'h80);
        reg_read(2'd2, r); chk("R11 rx byte", r, 8'hE1);
        ss_n_i = 1'b1;
        idle(4);
    endtask

    task automatic t_slave_ph1();
        logic [7:0] r, cap;
        sck_i = 1'b1;
        reg_write(2'd0, 8'h4C);
        reg_write(2'd2, 8'h71);
        ss_n_i = 1'b0;
        idle(4);
        s_shift(1'b1, 1'b1, 8'hC8, cap);
        chk("R10 miso ph1", cap, 8'h71);
        reg_read(2'd1, r); chk("R10 status ph1", r, 8'h80);
        reg_read(2'd2, r); chk("R10 rx ph1", r, 8'hC8);
        reg_write(2'd2, 8'h2B);
        s_shift(1'b1, 1'b1, 8'h19, cap);
        chk("R12 second miso", cap, 8'h2B);
        reg_read(2'd1, r); chk("R12 status", r, 8'h80);
        reg_read(2'd2, r); chk("R12 rx byte", r, 8'h19);
        s_shift(1'b1, 1'b1, 8'h44, cap);
        s_shift(1'b1, 1'b1, 8'h88, cap);
        reg_read(2'd1, r); chk("R13 status", r, 8'h80);
        reg_read(2'd2, r); chk("R13 first byte kept", r, 8'h44);
        ss_n_i = 1'b1;
        idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_master(1'b1, 1'b0, 1'b0, 2'b00, 8'hA5, 8'h3C);
        t_master(1'b0, 1'b0, 1'b1, 2'b01, 8'h1E, 8'hD2);
        t_master(1'b1, 1'b1, 1'b0, 2'b10, 8'h80, 8'h01);
        t_master(1'b0, 1'b1, 1'b1, 2'b11, 8'h6B, 8'hB6);
        t_collision();
        t_clear_order();
        t_fault();
        t_slave_ph0();
        t_slave_ph1();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule